// File: doc/BRIEF.md
# Task-File Hidden Configuration Window Decoder

This block sits between a host I/O strobe interface and a legacy disk task-file register block. Normally every host access goes straight through to the ordinary task-file registers: the pass-through select follows the strobe, and read data comes from the task file.

A fixed pattern of host accesses opens a hidden window. The pattern is two 16-bit reads of offset 1 in a row, followed at once by a byte write of 0x03 to offset 2. While the window is open, byte-sized accesses no longer reach the task file. They go to a small set of controller configuration registers held inside this block. A byte write of 0x83 to offset 2 closes the window again. Drivers use the window to set up read and write cycle timing, turn the controller on or off, read the bus-clock strap and program the miscellaneous options.

Top module: `tfcfg_window`

## Requirements
- R1: After a synchronous active-low reset the window is closed, and a later unlock shows control = 0x11, both timing registers = 0x00 and miscellaneous = 0x00.
- R2: The window opens after two consecutive 16-bit reads of offset 1 followed by a byte write of 0x03 to offset 2. A third or later such read still counts as the last two. Cycles with no strobe leave the sequence where it was. The three accesses of the sequence themselves pass through to the task file.
- R3: Any strobed access that does not fit the next step of the sequence returns the tracker to its start. This includes a byte read of offset 1, a wrong offset, a 16-bit write or a wrong key value. A broken sequence never opens the window.
- R4: While the window is closed, the task-file select equals the strobe and read data equals the task-file read data, for every offset and size.
- R5: While the window is open, byte accesses do not assert the task-file select. A 16-bit access still passes through and changes no hidden register.
- R6: While the window is open, a byte write of 0x83 to offset 2 is consumed (select low) and closes the window. The next access passes through.
- R7: Hidden offsets 0 (read timing) and 1 (write timing) store and return all 8 bits written. Byte read data is zero-extended to 16 bits.
- R8: Hidden offset 3 (control) accepts only 0x95 (enable) and 0x11 (disable). Any other written value is ignored.
- R9: Hidden offset 5 (strap) is read-only. It reads bit 0 = bus-clock strap input (0 = 33 MHz, 1 = 25 MHz) and the other bits as 0.
- R10: Hidden offset 6 (miscellaneous) stores bits 6:0 of a write. Bit 7 always reads 0.
- R11: While the window is open, byte accesses to offsets 2, 4 and 7 read as zero, and their writes change no hidden register. On offset 2 this holds for every value except 0x83.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_offset | input | 3 | Task-file register offset |
| acc_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| tf_rdata | input | 16 | Read data returned by the normal task file |
| strap_slow_bus | input | 1 | Bus-clock strap, 1 = 25 MHz |
| tf_sel | output | 1 | Access is routed to the normal task file |
| rd_data | output | 16 | Read data returned to the host |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, 16-bit host data, 8-bit hidden registers, and the standard probe offset, key offset and key values. With these values every task-file offset, both access sizes and both key values can be reached directly from the vector table. It checks every way a sequence can break (size, offset, direction, value, and a surplus probe read), then reset in the middle of an open window and both strap levels.

// File: rtl/tfcfg_pkg.sv
package tfcfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_state_e;

  // Next state of the unlock tracker for one strobed access while closed
  function automatic seq_state_e seq_advance(input seq_state_e cur, input logic is_probe);
    if (!is_probe) return SEQ_IDLE;
    case (cur)
      SEQ_IDLE: return SEQ_ONE;
      default:  return SEQ_TWO;
    endcase
  endfunction

  // Keep only the writable bits of a register image
  function automatic logic [7:0] apply_mask(input logic [7:0] val, input logic [7:0] mask);
    return val & mask;
  endfunction

  // Control register accepts only its two recognised codes
  function automatic logic ctrl_code_ok(input logic [7:0] val, input logic [7:0] on_code,
                                        input logic [7:0] off_code);
    return (val == on_code) || (val == off_code);
  endfunction

endpackage

// File: rtl/tfcfg_seq_tracker.sv
module tfcfg_seq_tracker
  import tfcfg_pkg::*;
#(
  parameter int OFS_W     = 3,
  parameter int REG_W     = 8,
  parameter int PROBE_OFS = 1,
  parameter int KEY_OFS   = 2,
  parameter int KEY_OPEN  = 8'h03,
  parameter int KEY_CLOSE = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_wide,
  input  logic [OFS_W-1:0] acc_offset,
  input  logic [REG_W-1:0] acc_wbyte,
  output logic             unlocked_q,
  output logic             open_evt,
  output logic             close_evt
);

  localparam logic [OFS_W-1:0] PROBE_O = OFS_W'(PROBE_OFS);
  localparam logic [OFS_W-1:0] KEY_O   = OFS_W'(KEY_OFS);
  localparam logic [REG_W-1:0] OPEN_V  = REG_W'(KEY_OPEN);
  localparam logic [REG_W-1:0] CLOSE_V = REG_W'(KEY_CLOSE);

  seq_state_e state_q, state_d;
  logic       is_probe;
  logic       byte_key_wr;

  assign is_probe    = acc_valid && !acc_write && acc_wide && (acc_offset == PROBE_O);
  assign byte_key_wr = acc_valid && acc_write && !acc_wide && (acc_offset == KEY_O);
  assign open_evt    = !unlocked_q && (state_q == SEQ_TWO) && byte_key_wr &&
                       (acc_wbyte == OPEN_V);
  assign close_evt   = unlocked_q && byte_key_wr && (acc_wbyte == CLOSE_V);

  always_comb begin
    state_d = state_q;
    if (unlocked_q || open_evt) begin
      state_d = SEQ_IDLE;
    end else if (acc_valid) begin
      state_d = seq_advance(state_q, is_probe);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      unlocked_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (open_evt) begin
        unlocked_q <= 1'b1;
      end else if (close_evt) begin
        unlocked_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tfcfg_regs.sv
module tfcfg_regs
  import tfcfg_pkg::*;
#(
  parameter int OFS_W     = 3,
  parameter int REG_W     = 8,
  parameter int RDTIM_OFS = 0,
  parameter int WRTIM_OFS = 1,
  parameter int CTRL_OFS  = 3,
  parameter int STRAP_OFS = 5,
  parameter int MISC_OFS  = 6,
  parameter int CTRL_ON   = 8'h95,
  parameter int CTRL_OFF  = 8'h11,
  parameter int MISC_MASK = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [REG_W-1:0] wbyte,
  input  logic             strap_bit,
  output logic [REG_W-1:0] rbyte
);

  localparam int NUM_TIM = 2;
  localparam logic [OFS_W-1:0] TIM_O [NUM_TIM] = '{OFS_W'(RDTIM_OFS), OFS_W'(WRTIM_OFS)};
  localparam logic [OFS_W-1:0] CTRL_O  = OFS_W'(CTRL_OFS);
  localparam logic [OFS_W-1:0] STRAP_O = OFS_W'(STRAP_OFS);
  localparam logic [OFS_W-1:0] MISC_O  = OFS_W'(MISC_OFS);
  localparam logic [REG_W-1:0] ON_V    = REG_W'(CTRL_ON);
  localparam logic [REG_W-1:0] OFF_V   = REG_W'(CTRL_OFF);
  localparam logic [REG_W-1:0] MISC_M  = REG_W'(MISC_MASK);

  logic [REG_W-1:0] tim_q [NUM_TIM];
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] misc_q;

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tim_q[g] <= '0;
      end else if (wr_en && (ofs == TIM_O[g])) begin
        tim_q[g] <= wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= OFF_V;
      misc_q <= '0;
    end else if (wr_en) begin
      if ((ofs == CTRL_O) && ctrl_code_ok(wbyte, ON_V, OFF_V)) begin
        ctrl_q <= wbyte;
      end
      if (ofs == MISC_O) begin
        misc_q <= apply_mask(wbyte, MISC_M);
      end
    end
  end

  always_comb begin
    rbyte = '0;
    for (int i = 0; i < NUM_TIM; i++) begin
      if (ofs == TIM_O[i]) rbyte = tim_q[i];
    end
    if (ofs == CTRL_O)  rbyte = ctrl_q;
    if (ofs == STRAP_O) rbyte = {{(REG_W-1){1'b0}}, strap_bit};
    if (ofs == MISC_O)  rbyte = misc_q;
  end

endmodule

// File: rtl/tfcfg_window.sv
module tfcfg_window #(
  parameter int OFS_W  = 3,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_wide,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              strap_slow_bus,
  output logic              tf_sel,
  output logic [DATA_W-1:0] rd_data
);

  logic             unlocked_q;
  logic             open_evt;
  logic             close_evt;
  logic             cfg_hit;
  logic             cfg_wr;
  logic [REG_W-1:0] cfg_rbyte;
  logic [REG_W-1:0] wbyte;
  logic             unused_hi;

  assign wbyte     = acc_wdata[REG_W-1:0];
  assign unused_hi = ^acc_wdata[DATA_W-1:REG_W];

  tfcfg_seq_tracker #(
    .OFS_W(OFS_W),
    .REG_W(REG_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_wide  (acc_wide),
    .acc_offset(acc_offset),
    .acc_wbyte (wbyte),
    .unlocked_q(unlocked_q),
    .open_evt  (open_evt),
    .close_evt (close_evt)
  );

  // Byte accesses are steered into the hidden space while the window is open
  assign cfg_hit = unlocked_q && !acc_wide;
  assign cfg_wr  = acc_valid && acc_write && cfg_hit;

  tfcfg_regs #(
    .OFS_W(OFS_W),
    .REG_W(REG_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .ofs      (acc_offset),
    .wbyte    (wbyte),
    .strap_bit(strap_slow_bus),
    .rbyte    (cfg_rbyte)
  );

  assign tf_sel  = acc_valid && !cfg_hit;
  assign rd_data = cfg_hit ? {{(DATA_W-REG_W){1'b0}}, cfg_rbyte} : tf_rdata;

endmodule

// File: rtl/tfcfg_window_chk.sv
module tfcfg_window_chk #(
  parameter int OFS_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_wide,
  input logic [OFS_W-1:0]  acc_offset,
  input logic [DATA_W-1:0] tf_rdata,
  input logic              strap_slow_bus,
  input logic              tf_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              unlocked_q,
  input logic              open_evt,
  input logic              close_evt
);

  logic byte_rd_open;
  assign byte_rd_open = acc_valid && unlocked_q && !acc_wide && !acc_write;

  assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> unlocked_q);

  assert_no_partial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_q && !open_evt) |=> !unlocked_q);

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |-> (tf_sel == acc_valid) && (rd_data == tf_rdata));

  assert_byte_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && unlocked_q && !acc_wide) |-> !tf_sel);

  assert_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> !unlocked_q);

  assert_ctrl_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd_open && acc_offset == OFS_W'(3)) |->
      (rd_data == DATA_W'(8'h95) || rd_data == DATA_W'(8'h11)));

  assert_strap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd_open && acc_offset == OFS_W'(5)) |-> (rd_data == DATA_W'(strap_slow_bus)));

  assert_misc_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rd_open && acc_offset == OFS_W'(6)) |-> (rd_data[DATA_W-1:7] == '0));

endmodule

bind tfcfg_window tfcfg_window_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_write     (acc_write),
  .acc_wide      (acc_wide),
  .acc_offset    (acc_offset),
  .tf_rdata      (tf_rdata),
  .strap_slow_bus(strap_slow_bus),
  .tf_sel        (tf_sel),
  .rd_data       (rd_data),
  .unlocked_q    (unlocked_q),
  .open_evt      (open_evt),
  .close_evt     (close_evt)
);

// File: tb/tfcfg_window_tb_top.sv
module tfcfg_window_tb_top;

  localparam logic [15:0] TF = 16'hA5C3;
  localparam int NV = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_wide = 1'b0;
  logic [2:0]  acc_offset = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] tf_rdata = TF;
  logic        strap_slow_bus = 1'b1;
  logic        tf_sel;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tfcfg_window dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .tf_rdata(tf_rdata), .strap_slow_bus(strap_slow_bus),
    .tf_sel(tf_sel), .rd_data(rd_data)
  );

  // {wr, wide, ofs[2:0], wdata[15:0], chk, exp_sel, exp_rd[15:0], req[3:0]}
  function automatic logic [42:0] v(input logic wr, input logic wide, input logic [2:0] o,
                                    input logic [15:0] wd, input logic chk, input logic sel,
                                    input logic [15:0] rd, input logic [3:0] rq);
    return {wr, wide, o, wd, chk, sel, rd, rq};
  endfunction

  localparam logic [42:0] VEC [NV] = '{
    v(0,0,3,16'h0000,1,1,TF,4),        // R4 closed after reset
    v(0,1,1,16'h0000,1,1,TF,2),        // R2 probe passes
    v(0,1,1,16'h0000,0,1,TF,2),
    v(1,0,2,16'h0003,1,1,TF,2),        // R2 key write passes
    v(0,0,3,16'h0000,1,0,16'h0011,1),  // R1 control reset
    v(0,0,0,16'h0000,1,0,16'h0000,1),  // R1 timing reset
    v(0,0,6,16'h0000,1,0,16'h0000,1),  // R1 misc reset
    v(0,0,5,16'h0000,1,0,16'h0001,9),  // R9 strap
    v(1,0,5,16'h0000,1,0,16'h0001,9),  // R9
    v(0,0,5,16'h0000,1,0,16'h0001,9),  // R9 unchanged
    v(1,0,0,16'h005A,0,0,16'h0000,7),
    v(0,0,0,16'h0000,1,0,16'h005A,7),  // R7
    v(1,0,1,16'h00C7,0,0,16'h0000,7),
    v(0,0,1,16'h0000,1,0,16'h00C7,7),  // R7
    v(0,0,0,16'h0000,1,0,16'h005A,7),  // R7
    v(1,0,3,16'h0095,0,0,16'h0000,8),
    v(0,0,3,16'h0000,1,0,16'h0095,8),  // R8
    v(1,0,3,16'h0042,0,0,16'h0000,8),
    v(0,0,3,16'h0000,1,0,16'h0095,8),  // R8 ignored
    v(1,0,3,16'h0011,0,0,16'h0000,8),
    v(0,0,3,16'h0000,1,0,16'h0011,8),  // R8
    v(1,0,6,16'h00FF,0,0,16'h0000,10),
    v(0,0,6,16'h0000,1,0,16'h007F,10), // R10
    v(1,0,6,16'h0080,0,0,16'h0000,10),
    v(0,0,6,16'h0000,1,0,16'h0000,10), // R10
    v(1,0,4,16'h0077,1,0,16'h0000,11), // R11
    v(0,0,4,16'h0000,1,0,16'h0000,11), // R11
    v(1,0,2,16'h0044,1,0,16'h0000,11), // R11
    v(0,0,2,16'h0000,1,0,16'h0000,11), // R11 still open
    v(1,0,7,16'h00FF,0,0,16'h0000,11),
    v(0,0,7,16'h0000,1,0,16'h0000,11), // R11
    v(0,0,0,16'h0000,1,0,16'h005A,11), // R11 nothing clobbered
    v(0,1,1,16'h0000,1,1,TF,5),        // R5 wide passes
    v(1,1,3,16'h0095,1,1,TF,5),        // R5
    v(0,0,3,16'h0000,1,0,16'h0011,5),  // R5 control untouched
    v(1,0,2,16'h0083,1,0,16'h0000,6),  // R6 consumed
    v(0,0,0,16'h0000,1,1,TF,6),        // R6 closed
    v(0,1,1,16'h0000,0,1,TF,3),
    v(0,0,1,16'h0000,1,1,TF,3),        // R3 byte read breaks
    v(0,1,1,16'h0000,0,1,TF,3),
    v(1,0,2,16'h0003,0,1,TF,3),
    v(0,0,0,16'h0000,1,1,TF,3),        // R3
    v(0,1,1,16'h0000,0,1,TF,3),
    v(0,1,1,16'h0000,0,1,TF,3),
    v(1,0,2,16'h0004,0,1,TF,3),
    v(0,0,0,16'h0000,1,1,TF,3),        // R3 wrong value
    v(0,1,1,16'h0000,0,1,TF,3),
    v(0,1,1,16'h0000,0,1,TF,3),
    v(0,1,2,16'h0000,0,1,TF,3),
    v(1,0,2,16'h0003,0,1,TF,3),
    v(0,0,0,16'h0000,1,1,TF,3),        // R3 wrong offset
    v(0,1,1,16'h0000,0,1,TF,3),
    v(0,1,1,16'h0000,0,1,TF,3),
    v(1,1,2,16'h0003,0,1,TF,3),
    v(0,0,0,16'h0000,1,1,TF,3),        // R3 wide key write
    v(0,1,1,16'h0000,0,1,TF,2),
    v(0,1,1,16'h0000,0,1,TF,2),
    v(0,1,1,16'h0000,0,1,TF,2),
    v(1,0,2,16'h0003,0,1,TF,2),
    v(0,0,0,16'h0000,1,0,16'h005A,2),  // R2 surplus probe, values kept
    v(0,0,1,16'h0000,1,0,16'h00C7,2),  // R2
    v(1,0,2,16'h0083,0,0,16'h0000,6),
    v(0,0,0,16'h0000,1,1,TF,6)         // R6
  };

  task automatic check(input logic sel, input logic [15:0] rd, input int rq);
    n_chk++;
    if (tf_sel !== sel || rd_data !== rd) begin
      n_bad++;
      $display("FAIL R%0d: tf_sel=%0b rd_data=%h expected tf_sel=%0b rd_data=%h",
               rq, tf_sel, rd_data, sel, rd);
    end
  endtask

  task automatic access(input logic wr, input logic wide, input logic [2:0] o,
                        input logic [15:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_offset = o; acc_wdata = wd;
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
    end
  endtask

  task automatic unlock_gapped();
    access(0, 1, 1, 16'h0); idle(2);
    access(0, 1, 1, 16'h0); idle(3);
    access(1, 0, 2, 16'h0003); idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][42], VEC[i][41], VEC[i][40:38], VEC[i][37:22]);
      if (VEC[i][21]) check(VEC[i][20], VEC[i][19:4], int'(VEC[i][3:0]));
    end

    // R2 idle cycles inside the sequence do not break it
    unlock_gapped();
    access(0, 0, 1, 16'h0); check(1'b0, 16'h00C7, 2);

    // R1 reset while open closes the window and restores defaults
    @(negedge clk); acc_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(0, 0, 3, 16'h0); check(1'b1, TF, 1);
    unlock_gapped();
    access(0, 0, 3, 16'h0); check(1'b0, 16'h0011, 1);
    access(0, 0, 0, 16'h0); check(1'b0, 16'h0000, 1);
    access(0, 0, 1, 16'h0); check(1'b0, 16'h0000, 1);

    // R9 strap low reads zero
    strap_slow_bus = 1'b0;
    access(0, 0, 5, 16'h0); check(1'b0, 16'h0000, 9);

    // R4 closed window follows task-file data
    access(1, 0, 2, 16'h0083);
    tf_rdata = 16'h1E2D;
    access(0, 0, 5, 16'h0); check(1'b1, 16'h1E2D, 4);
    idle(1); #2; check(1'b0, 16'h1E2D, 4);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule